// File: doc/BRIEF.md
# Secure AES key slot store

This block stores AES keys and initialisation vectors for a cipher engine. It has a fixed number of numbered slots, and each slot holds one 128-bit key and one 128-bit IV. Software reaches the slots through a word-wide command port. Over that port it can load words, read them back, wipe a whole slot or only its IV, and tighten access. The permission controls are a lock bit per slot, a global switch that stops key readback, and a one-way engine switch. Software can set any of these but cannot clear them. Only the active-low reset clears them.

The cipher datapath has its own port. A select request returns the key and IV of a chosen slot one cycle later. After each operation the datapath writes the chained IV back into the slot it used, so chaining carries on from one operation to the next. Slots 0 to 3 are the base set and slots 4 to 7 are the extended set. All eight behave the same way.

Top module: `aes_key_vault`

## Requirements
- R1: After reset every key and IV is zero, no slot is locked, key reads are allowed, `engine_off_o` is 0 and every output is zero.
- R2: `cmd_i` codes: 0 write key word, 1 write IV word, 2 read key word, 3 read IV word, 4 clear key and IV, 5 clear IV, 6 lock slot, 7 kill key reads, 8 disable engine. `word_i` selects bits `[32*word_i +: 32]`. A write takes effect at the edge that samples `req_i`. A read returns `rdata_o` with `rvalid_o`=1 on the next cycle. An accepted command leaves `err_o`=0.
- R3: Clear key and IV zeroes both the key and the IV of the addressed slot and leaves every other slot untouched.
- R4: Clear IV zeroes only the IV of the addressed slot and keeps its key.
- R5: Once a slot is locked, every write, read and clear on that slot is refused. A refused command gives `err_o`=1 for one cycle with `rdata_o`=0 and `rvalid_o`=0, and changes no stored value. The lock is never released except by reset.
- R6: After kill key reads, a key read on any slot is refused. IV reads of unlocked slots and datapath selects still work. Only reset undoes it.
- R7: Disable engine sets `engine_off_o` and keeps it set until reset. While it is set, every command is refused, and a select returns `sel_ok_o`=0 with zero key and IV.
- R8: A select with `sel_valid_i` returns `sel_ok_o`=1 and the key and IV of `sel_slot_i` on the next cycle, whatever the lock and kill state.
- R9: An IV write-back replaces the whole IV of `wb_slot_i` at the sampling edge, even on a locked slot. In the same cycle it takes priority over a command that writes that IV.
- R10: An unknown command code (9 to 15) is refused with `err_o`=1 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command code |
| slot_i | input | 3 | Addressed slot |
| word_i | input | 2 | 32-bit word within key or IV |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when refused |
| rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Command refused, one-cycle pulse |
| sel_valid_i | input | 1 | Datapath select request |
| sel_slot_i | input | 3 | Slot to select |
| sel_ok_o | output | 1 | Select granted |
| sel_key_o | output | 128 | Selected key |
| sel_iv_o | output | 128 | Selected IV |
| wb_valid_i | input | 1 | IV write-back strobe |
| wb_slot_i | input | 3 | Write-back slot |
| wb_iv_i | input | 128 | Updated IV |
| engine_off_o | output | 1 | Engine disabled status |

## Verification
The bench targets the corner cases where the permission rules interact.

- **Locked slot.** A wipe or write attempted on a locked slot is checked through the select port. A design that let the wipe through would return a zero key there.
- **Write-back on a locked slot.** The datapath writes an IV back to a locked slot. A design that applied the lock to the datapath as well would break IV chaining.
- **Kill key reads.** After the kill, IV reads are still tried. A design that killed every read would refuse them too.
- **Write-back racing a command.** A write-back and a command IV write hit the same slot in the same cycle, to catch a design that gives the command priority.
- **Disable and reset.** After disable, the bench applies reset and then reads the store back. A design whose disable survived reset, or whose slots kept stale data, is caught here.

// File: rtl/vault_pkg.sv
package vault_pkg;
  localparam int CMD_W = 4;
  typedef enum logic [CMD_W-1:0] {
    CMD_WR_KEY  = 4'd0,
    CMD_WR_IV   = 4'd1,
    CMD_RD_KEY  = 4'd2,
    CMD_RD_IV   = 4'd3,
    CMD_CLR_ALL = 4'd4,
    CMD_CLR_IV  = 4'd5,
    CMD_LOCK    = 4'd6,
    CMD_KILL_RD = 4'd7,
    CMD_DISABLE = 4'd8
  } vault_cmd_e;
endpackage

// File: rtl/vault_guard.sv
module vault_guard
  import vault_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  vault_cmd_e           cmd_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic                 ok_o,
  output logic [NUM_SLOTS-1:0] lock_o,
  output logic                 kill_o,
  output logic                 off_o
);
  logic [NUM_SLOTS-1:0] lock_q;
  logic kill_q, off_q, slot_free;

  assign slot_free = !lock_q[slot_i];

  always_comb begin
    ok_o = 1'b0;
    if (!off_q) begin
      unique case (cmd_i)
        CMD_WR_KEY, CMD_WR_IV, CMD_RD_IV,
        CMD_CLR_ALL, CMD_CLR_IV:          ok_o = slot_free;
        CMD_RD_KEY:                       ok_o = slot_free && !kill_q;
        CMD_LOCK, CMD_KILL_RD, CMD_DISABLE: ok_o = 1'b1;
        default:                          ok_o = 1'b0;
      endcase
    end
  end

  // set-only controls; reset is the sole way back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      kill_q <= 1'b0;
      off_q  <= 1'b0;
    end else if (req_i && ok_o) begin
      if (cmd_i == CMD_LOCK)    lock_q[slot_i] <= 1'b1;
      if (cmd_i == CMD_KILL_RD) kill_q <= 1'b1;
      if (cmd_i == CMD_DISABLE) off_q  <= 1'b1;
    end
  end

  assign lock_o = lock_q;
  assign kill_o = kill_q;
  assign off_o  = off_q;
endmodule

// File: rtl/vault_store.sv
module vault_store #(
  parameter int NUM_SLOTS = 8,
  parameter int BLK_W     = 128,
  parameter int WORD_W    = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int WSEL_W = $clog2(BLK_W / WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_key_i,
  input  logic              wr_iv_i,
  input  logic              clr_all_i,
  input  logic              clr_iv_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WSEL_W-1:0] word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wb_en_i,
  input  logic [SLOT_W-1:0] wb_slot_i,
  input  logic [BLK_W-1:0]  wb_iv_i,
  output logic [BLK_W-1:0]  key_o [NUM_SLOTS],
  output logic [BLK_W-1:0]  iv_o  [NUM_SLOTS]
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(i);
    logic [BLK_W-1:0] key_q, iv_q;
    logic hit;
    assign hit = (slot_i == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q <= '0;
        iv_q  <= '0;
      end else begin
        if (hit && clr_all_i) begin
          key_q <= '0;
          iv_q  <= '0;
        end
        if (hit && clr_iv_i) iv_q <= '0;
        if (hit && wr_key_i) key_q[word_i*WORD_W +: WORD_W] <= wdata_i;
        if (hit && wr_iv_i)  iv_q[word_i*WORD_W +: WORD_W]  <= wdata_i;
        // datapath chaining has the last word
        if (wb_en_i && wb_slot_i == IDX) iv_q <= wb_iv_i;
      end
    end

    assign key_o[i] = key_q;
    assign iv_o[i]  = iv_q;
  end
endmodule

// File: rtl/aes_key_vault.sv
module aes_key_vault
  import vault_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int BLK_W     = 128,
  parameter int WORD_W    = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int WSEL_W = $clog2(BLK_W / WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WSEL_W-1:0] word_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  input  logic              sel_valid_i,
  input  logic [SLOT_W-1:0] sel_slot_i,
  output logic              sel_ok_o,
  output logic [BLK_W-1:0]  sel_key_o,
  output logic [BLK_W-1:0]  sel_iv_o,
  input  logic              wb_valid_i,
  input  logic [SLOT_W-1:0] wb_slot_i,
  input  logic [BLK_W-1:0]  wb_iv_i,
  output logic              engine_off_o
);
  vault_cmd_e cmd;
  logic ok, go, rd_kill, eng_off, is_read;
  logic [NUM_SLOTS-1:0] lock_vec;
  logic [BLK_W-1:0] key_arr [NUM_SLOTS];
  logic [BLK_W-1:0] iv_arr  [NUM_SLOTS];
  logic [BLK_W-1:0] rd_blk;

  assign cmd = vault_cmd_e'(cmd_i);
  assign go  = req_i && ok;
  assign is_read = (cmd == CMD_RD_KEY) || (cmd == CMD_RD_IV);

  vault_guard #(.NUM_SLOTS(NUM_SLOTS)) u_guard (
    .clk_i, .rst_ni, .req_i, .cmd_i(cmd), .slot_i,
    .ok_o(ok), .lock_o(lock_vec), .kill_o(rd_kill), .off_o(eng_off)
  );

  vault_store #(.NUM_SLOTS(NUM_SLOTS), .BLK_W(BLK_W), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .wr_key_i (go && cmd == CMD_WR_KEY),
    .wr_iv_i  (go && cmd == CMD_WR_IV),
    .clr_all_i(go && cmd == CMD_CLR_ALL),
    .clr_iv_i (go && cmd == CMD_CLR_IV),
    .slot_i, .word_i, .wdata_i,
    .wb_en_i  (wb_valid_i && !eng_off),
    .wb_slot_i, .wb_iv_i,
    .key_o(key_arr), .iv_o(iv_arr)
  );

  assign rd_blk = (cmd == CMD_RD_IV) ? iv_arr[slot_i] : key_arr[slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      err_o     <= 1'b0;
      sel_ok_o  <= 1'b0;
      sel_key_o <= '0;
      sel_iv_o  <= '0;
    end else begin
      rvalid_o <= go && is_read;
      err_o    <= req_i && !ok;
      rdata_o  <= (go && is_read) ? rd_blk[word_i*WORD_W +: WORD_W] : '0;
      sel_ok_o <= sel_valid_i && !eng_off;
      if (sel_valid_i && !eng_off) begin
        sel_key_o <= key_arr[sel_slot_i];
        sel_iv_o  <= iv_arr[sel_slot_i];
      end else if (sel_valid_i) begin
        sel_key_o <= '0;
        sel_iv_o  <= '0;
      end
    end
  end

  assign engine_off_o = eng_off;
endmodule

// File: rtl/vault_chk.sv
module vault_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 err_o,
  input logic                 rvalid_o,
  input logic [WORD_W-1:0]    rdata_o,
  input logic                 sel_valid_i,
  input logic                 sel_ok_o,
  input logic                 engine_off_o,
  input logic [NUM_SLOTS-1:0] lock_i,
  input logic                 kill_i
);
  assert_err_from_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));
  assert_rvalid_xor_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rvalid_o && err_o));
  assert_refused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_i) & ~lock_i) == '0);
  assert_kill_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> kill_i);
  assert_off_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_off_o |=> engine_off_o);
  assert_off_blocks_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(engine_off_o) |-> !sel_ok_o);
  assert_sel_from_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ok_o |-> $past(sel_valid_i));
endmodule

bind aes_key_vault vault_chk #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .err_o(err_o),
  .rvalid_o(rvalid_o), .rdata_o(rdata_o), .sel_valid_i(sel_valid_i),
  .sel_ok_o(sel_ok_o), .engine_off_o(engine_off_o),
  .lock_i(lock_vec), .kill_i(rd_kill)
);

// File: tb/aes_key_vault_tb.sv
module aes_key_vault_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [3:0] cmd_i = '0;
  logic [2:0] slot_i = '0;
  logic [1:0] word_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic rvalid_o, err_o;
  logic sel_valid_i = 1'b0;
  logic [2:0] sel_slot_i = '0;
  logic sel_ok_o;
  logic [127:0] sel_key_o, sel_iv_o;
  logic wb_valid_i = 1'b0;
  logic [2:0] wb_slot_i = '0;
  logic [127:0] wb_iv_i = '0;
  logic engine_off_o;

  always #5 clk_i = ~clk_i;

  aes_key_vault u_dut (.*);

  typedef struct {
    bit is_sel;
    logic err, rv, ok;
    logic [31:0] rd;
    logic [127:0] k, iv;
    string tag;
  } exp_t;
  exp_t q[$];

  logic [127:0] mkey [8];
  logic [127:0] miv [8];
  logic [7:0] mlock;
  logic mkill, moff;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin mkey[s] = '0; miv[s] = '0; end
    mlock = '0; mkill = 1'b0; moff = 1'b0;
  endtask

  task automatic chk(input bit c, input string tag, input logic [127:0] act, exp_v);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  function automatic bit allowed(input int c, input int s);
    if (moff) return 0;
    case (c)
      0, 1, 3, 4, 5: return !mlock[s];
      2: return !mlock[s] && !mkill;
      6, 7, 8: return 1;
      default: return 0;
    endcase
  endfunction

  // driver: one command, optionally with a same-cycle IV write-back
  task automatic op(input int c, input int s, input int w, input logic [31:0] d,
                    input string tag, input bit wb = 0, input int wbs = 0,
                    input logic [127:0] wbd = '0);
    exp_t e;
    bit ok;
    @(negedge clk_i);
    req_i = 1; cmd_i = 4'(c); slot_i = 3'(s); word_i = 2'(w); wdata_i = d;
    wb_valid_i = wb; wb_slot_i = 3'(wbs); wb_iv_i = wbd;
    ok = allowed(c, s);
    e.is_sel = 0; e.tag = tag; e.err = !ok; e.ok = 0; e.k = '0; e.iv = '0;
    e.rv = ok && (c == 2 || c == 3);
    e.rd = !e.rv ? 32'h0 : (c == 2 ? mkey[s][w*32 +: 32] : miv[s][w*32 +: 32]);
    if (ok) begin
      case (c)
        0: mkey[s][w*32 +: 32] = d;
        1: miv[s][w*32 +: 32] = d;
        4: begin mkey[s] = '0; miv[s] = '0; end
        5: miv[s] = '0;
        6: mlock[s] = 1'b1;
        7: mkill = 1'b1;
        8: moff = 1'b1;
        default: ;
      endcase
    end
    if (wb && !moff) miv[wbs] = wbd;
    @(posedge clk_i); #1;
    q.push_back(e);
    req_i = 0; wb_valid_i = 0;
  endtask

  task automatic sel(input int s, input string tag);
    exp_t e;
    @(negedge clk_i);
    sel_valid_i = 1; sel_slot_i = 3'(s);
    e.is_sel = 1; e.tag = tag; e.err = 0; e.rv = 0; e.rd = '0;
    e.ok = !moff; e.k = moff ? '0 : mkey[s]; e.iv = moff ? '0 : miv[s];
    @(posedge clk_i); #1;
    q.push_back(e);
    sel_valid_i = 0;
  endtask

  task automatic wback(input int s, input logic [127:0] d);
    @(negedge clk_i);
    wb_valid_i = 1; wb_slot_i = 3'(s); wb_iv_i = d;
    if (!moff) miv[s] = d;
    @(posedge clk_i); #1;
    wb_valid_i = 0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.is_sel) begin
        chk(sel_ok_o === e.ok, {e.tag, " sel_ok"}, 128'(sel_ok_o), 128'(e.ok));
        chk(sel_key_o === e.k, {e.tag, " key"}, sel_key_o, e.k);
        chk(sel_iv_o === e.iv, {e.tag, " iv"}, sel_iv_o, e.iv);
      end else begin
        chk(err_o === e.err, {e.tag, " err"}, 128'(err_o), 128'(e.err));
        chk(rvalid_o === e.rv, {e.tag, " rvalid"}, 128'(rvalid_o), 128'(e.rv));
        chk(rdata_o === e.rd, {e.tag, " rdata"}, 128'(rdata_o), 128'(e.rd));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk(engine_off_o === 1'b0, "R1 engine_off", 128'(engine_off_o), 0);
    chk(err_o === 1'b0 && rvalid_o === 1'b0, "R1 err/rvalid", 128'({err_o, rvalid_o}), 0);
    op(2, 5, 1, 0, "R1 key read after reset");
    sel(7, "R1 select after reset");
    // R2 load every slot, read back
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++) begin
        op(0, s, w, 32'hA000_0000 | (s << 8) | w, "R2 wr key");
        op(1, s, w, 32'hB000_0000 | (s << 8) | w, "R2 wr iv");
      end
    op(2, 6, 3, 0, "R2 rd key");
    op(3, 1, 2, 0, "R2 rd iv");
    // R8 select
    sel(3, "R8 select slot3");
    sel(4, "R8 select slot4");
    // R4 clear iv only
    op(5, 3, 0, 0, "R4 clr iv");
    op(2, 3, 1, 0, "R4 key kept");
    op(3, 3, 1, 0, "R4 iv zero");
    sel(3, "R4 select");
    // R3 clear key and iv
    op(4, 2, 0, 0, "R3 clr all");
    sel(2, "R3 slot2 zero");
    sel(1, "R3 neighbour intact");
    // R9 write-back, and priority over same-cycle write
    wback(4, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    sel(4, "R9 writeback");
    op(1, 6, 2, 32'hDEAD_BEEF, "R9 race wr", 1, 6, 128'hCAFE_F00D_0000_0000_1234_5678_9ABC_DEF0);
    op(3, 6, 2, 0, "R9 writeback wins");
    // R5 lock
    op(6, 5, 0, 0, "R5 lock");
    op(0, 5, 0, 32'h1234_5678, "R5 wr refused");
    op(2, 5, 0, 0, "R5 rd refused");
    op(4, 5, 0, 0, "R5 clr refused");
    op(3, 5, 0, 0, "R5 iv rd refused");
    sel(5, "R5 content kept");
    wback(5, 128'hFEED_0000_FEED_0000_FEED_0000_FEED_0001);
    sel(5, "R9 writeback locked");
    op(6, 5, 0, 0, "R5 relock");
    op(1, 5, 0, 0, "R5 still locked");
    // R6 kill key reads
    op(7, 0, 0, 0, "R6 kill");
    op(2, 0, 0, 0, "R6 key rd refused");
    op(2, 7, 3, 0, "R6 key rd refused slot7");
    op(3, 0, 2, 0, "R6 iv rd allowed");
    sel(0, "R6 select still works");
    op(0, 0, 1, 32'h0BAD_F00D, "R6 write allowed");
    sel(0, "R6 write landed");
    // R10 unknown code
    op(12, 1, 0, 32'hFFFF_FFFF, "R10 unknown");
    sel(1, "R10 no effect");
    // R7 disable
    op(8, 0, 0, 0, "R7 disable");
    @(negedge clk_i);
    chk(engine_off_o === 1'b1, "R7 engine_off set", 128'(engine_off_o), 1);
    op(0, 1, 0, 32'h5555_5555, "R7 wr refused");
    op(3, 1, 0, 0, "R7 rd refused");
    op(8, 0, 0, 0, "R7 disable again refused");
    sel(1, "R7 select blocked");
    wback(1, '1);
    repeat (3) @(negedge clk_i);
    chk(engine_off_o === 1'b1, "R7 sticky", 128'(engine_off_o), 1);
    do_reset();
    chk(engine_off_o === 1'b0, "R7 reset clears", 128'(engine_off_o), 0);
    sel(1, "R1 store wiped by reset");
    op(2, 0, 1, 0, "R6 kill cleared by reset");
    op(0, 5, 0, 32'h7777_0001, "R5 lock cleared by reset");
    op(2, 5, 0, 0, "R5 readback after reset");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule